// File: doc/BRIEF.md
# Double-Buffered Control Register Bank with Synchronized Commit

This block holds the control registers of a clocked signal-generator core in two copies. A write port fills a staging (shadow) copy at any time. The live (active) copy that drives the core takes the staging contents only when an external commit strobe rises. That strobe is observed in a slow synchronization clock, which the block derives by dividing the system clock by four. Because every transfer is timed by that slow clock, the delay from a commit request to new live values is the same every time when measured in system clock cycles.

The synchronization clock is brought out on a pin, so that external logic can time its strobe from the same clock. An input can gate this pin off, but the divider keeps counting inside the block. The control register also selects an externally driven shaped keying mode. In that mode the amplitude register supplies the scale factor of the data path. Because the value comes from the live copy, it changes only when a transfer takes place.

Top module: `dbuf_update_bank`

## Requirements
- R1: `sync_clk_out` has one quarter of the `clk` rate, with a duty of two high cycles in four. Counting from the release of `rst_n`, it first goes high after the second rising edge of `clk`.
- R2: While `sync_clk_off` is 1, `sync_clk_out` is 0. When the gate is released, the waveform continues in the phase the divider would have had with no gating at all.
- R3: `commit_req` is sampled only on rising edges of the synchronization clock. New live values appear at the third synchronization rising edge, counting the first edge that samples `commit_req` high as the first.
- R4: Each low-to-high change of the sampled `commit_req` causes exactly one transfer. Holding `commit_req` high for any length of time causes no further transfer.
- R5: A staging write has no effect on `active_regs` until a transfer happens. This includes a write made while `commit_req` is held high after a transfer.
- R6: A transfer copies every register of the staging copy into the live copy on the same `clk` edge.
- R7: While `rst_n` is 0, both copies are cleared to zero and the divider phase is reset.
- R8: `key_ext` is 1 exactly when live register 0 has bit 25 set and bit 24 clear.
- R9: When `key_ext` is 1, `amp_scale` equals bits 13:0 of live register 1. Otherwise `amp_scale` is full scale, 0x3FFF.
- R10: A staging write on the same `clk` edge as a transfer goes into the staging copy only. The live copy receives the staging contents as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Staging write strobe |
| wr_addr | input | 2 | Staging register index |
| wr_data | input | 32 | Staging write data |
| commit_req | input | 1 | Commit strobe; a rising edge requests a transfer |
| sync_clk_off | input | 1 | Gates the exported synchronization clock low |
| sync_clk_out | output | 1 | System clock divided by four |
| active_regs | output | 128 | Live register copy, register i in bits 32*i+31 : 32*i |
| key_ext | output | 1 | External shaped keying mode selected |
| amp_scale | output | 14 | Data-path amplitude scale factor |

## Verification
The bench holds `commit_req` high for many synchronization periods and writes new staging data during that time. A design that detected levels rather than edges would commit repeatedly and expose those writes early. It measures the commit latency in synchronization edges; a synchronizer stage too many or too few would shift the live update by four system cycles. It also writes to the staging copy on the very edge of a transfer, where a wrongly ordered bank would publish the new word. Finally, it gates the exported clock and checks that the phase stays put afterwards, which catches a divider that stalls while gated.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

  typedef enum logic [1:0] {
    KEY_NONE = 2'b00,
    KEY_AUTO = 2'b01,
    KEY_EXT  = 2'b10,
    KEY_BOTH = 2'b11
  } key_mode_t;

  // Keying mode from the two control bits: {ext_bit, auto_bit}.
  function automatic key_mode_t key_decode(input logic ext_bit, input logic auto_bit);
    return key_mode_t'({ext_bit, auto_bit});
  endfunction

  // Next divider phase with wrap at div-1.
  function automatic int unsigned phase_next(input int unsigned phase, input int unsigned div);
    return (phase == div - 1) ? 0 : phase + 1;
  endfunction

endpackage

// File: rtl/sync_clk_div.sv
module sync_clk_div #(
  parameter int DIV = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gate_off,
  output logic [$clog2(DIV)-1:0]   phase,
  output logic                     tick,
  output logic                     clk_out
);
  import dbuf_pkg::*;

  localparam int CNT_W = $clog2(DIV);
  localparam int HALF  = DIV / 2;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CNT_W'(phase_next(int'(cnt), DIV));
  end

  // tick marks the clk edge on which the divided clock rises
  assign tick    = (cnt == CNT_W'(HALF - 1));
  assign phase   = cnt;
  assign clk_out = (cnt >= CNT_W'(HALF)) & ~gate_off;

endmodule

// File: rtl/update_edge_detect.sv
module update_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic commit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else if (tick) begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign commit = tick & sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/shadow_active_bank.sv
module shadow_active_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int FLAT_W  = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  output logic [FLAT_W-1:0] active_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      shadow_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))         shadow_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      active_q <= '0;
      else if (commit) active_q <= shadow_q;
    end

    assign active_flat[i*DATA_W +: DATA_W] = active_q;
  end

endmodule

// File: rtl/dbuf_update_bank.sv
module dbuf_update_bank #(
  parameter int NUM_REGS     = 4,
  parameter int DATA_W       = 32,
  parameter int DIV          = 4,
  parameter int CTRL_IDX     = 0,
  parameter int AMP_IDX      = 1,
  parameter int KEY_EXT_BIT  = 25,
  parameter int KEY_AUTO_BIT = 24,
  parameter int AMP_W        = 14,
  localparam int ADDR_W      = $clog2(NUM_REGS),
  localparam int FLAT_W      = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit_req,
  input  logic              sync_clk_off,
  output logic              sync_clk_out,
  output logic [FLAT_W-1:0] active_regs,
  output logic              key_ext,
  output logic [AMP_W-1:0]  amp_scale
);
  import dbuf_pkg::*;

  logic [$clog2(DIV)-1:0] div_phase;
  logic                   sync_tick;
  logic                   commit_pulse;
  logic [DATA_W-1:0]      ctrl_word;
  logic [DATA_W-1:0]      amp_word;
  key_mode_t              key_mode;

  sync_clk_div #(.DIV(DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_off (sync_clk_off),
    .phase    (div_phase),
    .tick     (sync_tick),
    .clk_out  (sync_clk_out)
  );

  update_edge_detect #(.SYNC_STAGES(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (sync_tick),
    .pin    (commit_req),
    .commit (commit_pulse)
  );

  shadow_active_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .commit      (commit_pulse),
    .active_flat (active_regs)
  );

  assign ctrl_word = active_regs[CTRL_IDX*DATA_W +: DATA_W];
  assign amp_word  = active_regs[AMP_IDX*DATA_W +: DATA_W];
  assign key_mode  = key_decode(ctrl_word[KEY_EXT_BIT], ctrl_word[KEY_AUTO_BIT]);
  assign key_ext   = (key_mode == KEY_EXT);
  assign amp_scale = key_ext ? amp_word[AMP_W-1:0] : {AMP_W{1'b1}};

endmodule

// File: rtl/dbuf_update_bank_chk.sv
module dbuf_update_bank_chk #(
  parameter int FLAT_W = 128,
  parameter int AMP_W  = 14,
  parameter int DIV    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [$clog2(DIV)-1:0] div_phase,
  input logic                   sync_tick,
  input logic                   sync_clk_off,
  input logic                   sync_clk_out,
  input logic                   commit_pulse,
  input logic                   commit_req,
  input logic [FLAT_W-1:0]      active_regs,
  input logic                   key_ext,
  input logic [AMP_W-1:0]       amp_scale
);
  localparam int CNT_W = $clog2(DIV);

  assert_div_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_phase) == CNT_W'(DIV - 1)) |-> (div_phase == '0));

  assert_gate_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clk_off |-> !sync_clk_out);

  assert_commit_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> sync_tick);

  assert_single_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse);

  assert_hold_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_pulse |=> $stable(active_regs));

  assert_full_scale_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !key_ext |-> (amp_scale == {AMP_W{1'b1}}));

endmodule

bind dbuf_update_bank dbuf_update_bank_chk #(
  .FLAT_W (FLAT_W),
  .AMP_W  (AMP_W),
  .DIV    (DIV)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .div_phase    (div_phase),
  .sync_tick    (sync_tick),
  .sync_clk_off (sync_clk_off),
  .sync_clk_out (sync_clk_out),
  .commit_pulse (commit_pulse),
  .commit_req   (commit_req),
  .active_regs  (active_regs),
  .key_ext      (key_ext),
  .amp_scale    (amp_scale)
);

// File: tb/dbuf_update_bank_test.sv
module dbuf_update_bank_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         commit_req = 1'b0;
  logic         sync_clk_off = 1'b0;
  logic         sync_clk_out;
  logic [127:0] active_regs;
  logic         key_ext;
  logic [13:0]  amp_scale;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_shadow [4];
  logic [31:0] m_active [4];
  int m_phase = 0;
  bit m_last_pin = 0;
  int m_countdown = 0;

  always #2 clk = ~clk;

  dbuf_update_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_req(commit_req), .sync_clk_off(sync_clk_off), .sync_clk_out(sync_clk_out),
    .active_regs(active_regs), .key_ext(key_ext), .amp_scale(amp_scale)
  );

  function automatic logic [31:0] act(input int i);
    return active_regs[i*32 +: 32];
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // one upcoming clk edge applied to the model with the current inputs
  task automatic model_step();
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_shadow[i] = '0; m_active[i] = '0; end
      m_phase = 0; m_last_pin = 0; m_countdown = 0;
    end else begin
      if (m_phase == 1) begin
        if (m_countdown == 1)
          for (int i = 0; i < 4; i++) m_active[i] = m_shadow[i];
        if (m_countdown > 0) m_countdown--;
        if (commit_req && !m_last_pin) m_countdown = 2;
        m_last_pin = commit_req;
      end
      if (wr_en) m_shadow[wr_addr] = wr_data;
      m_phase = (m_phase + 1) % 4;
    end
  endtask

  task automatic model_compare();
    logic ext;
    logic [13:0] amp;
    check("R1/R2 sync_clk_out", 32'(sync_clk_out), 32'((m_phase >= 2) && !sync_clk_off));
    for (int i = 0; i < 4; i++) check("R5/R6/R10 active", act(i), m_active[i]);
    ext = m_active[0][25] && !m_active[0][24];
    amp = ext ? m_active[1][13:0] : 14'h3FFF;
    check("R8 key_ext", 32'(key_ext), 32'(ext));
    check("R9 amp_scale", 32'(amp_scale), 32'(amp));
  endtask

  task automatic cycle();
    model_step();
    @(negedge clk);
    model_compare();
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic write(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cycle();
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int rises;
    bit prev;
    @(negedge clk);
    cycles(3);
    // R7 reset state
    for (int i = 0; i < 4; i++) check("R7 reset active", act(i), 32'h0);
    check("R7 reset amp", 32'(amp_scale), 32'h3FFF);
    rst_n = 1'b1;
    // R1: first rise after second edge, then ratio 4
    cycle();
    check("R1 low after 1st edge", 32'(sync_clk_out), 32'h0);
    cycle();
    check("R1 high after 2nd edge", 32'(sync_clk_out), 32'h1);
    rises = 0; prev = sync_clk_out;
    for (int k = 0; k < 40; k++) begin
      cycle();
      if (sync_clk_out && !prev) rises++;
      prev = sync_clk_out;
    end
    check("R1 rises in 40 cycles", 32'(rises), 32'd10);
    // R2 gating
    sync_clk_off = 1'b1;
    rises = 0;
    for (int k = 0; k < 13; k++) begin cycle(); if (sync_clk_out) rises++; end
    check("R2 gated high count", 32'(rises), 32'd0);
    sync_clk_off = 1'b0;
    cycles(5);
    // R5 staging writes do not reach the live copy
    write(2'd0, 32'h0200_0000);
    write(2'd1, 32'h0000_1234);
    write(2'd2, 32'hA5A5_0002);
    write(2'd3, 32'hC3C3_0003);
    cycles(12);
    check("R5 no commit yet", act(1), 32'h0);
    // R3 latency in sync edges
    commit_req = 1'b1;
    rises = 0; prev = sync_clk_out;
    for (int k = 0; k < 30 && act(1) == 32'h0; k++) begin
      cycle();
      if (sync_clk_out && !prev) rises++;
      prev = sync_clk_out;
    end
    check("R3 latency sync edges", 32'(rises), 32'd3);
    check("R6 reg3 copied", act(3), 32'hC3C3_0003);
    check("R8 ext mode", 32'(key_ext), 32'h1);
    check("R9 amp from reg", 32'(amp_scale), 32'h1234);
    // R4/R5 held high, new staging data stays staged
    write(2'd1, 32'h0000_0ABC);
    cycles(40);
    check("R4 no repeat transfer", act(1), 32'h0000_1234);
    commit_req = 1'b0;
    cycles(8);
    commit_req = 1'b1;
    cycles(16);
    check("R4 next rise commits", act(1), 32'h0000_0ABC);
    commit_req = 1'b0;
    cycles(8);
    // R8 both bits set: not external mode
    write(2'd0, 32'h0300_0000);
    commit_req = 1'b1;
    cycles(16);
    check("R8 both bits not ext", 32'(key_ext), 32'h0);
    check("R9 full scale", 32'(amp_scale), 32'h3FFF);
    commit_req = 1'b0;
    cycles(8);
    // R10 writes every cycle across a transfer edge
    commit_req = 1'b1;
    for (int k = 0; k < 20; k++) begin
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h5000_0000 + 32'(k);
      cycle();
    end
    wr_en = 1'b0;
    commit_req = 1'b0;
    cycles(12);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule